// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned binary operands and a carry-in in a single combinational pass. Carries are not rippled bit by bit; each nibble of the operands feeds a lookahead unit that turns four per-bit propagate/generate pairs into the three carries inside the nibble. It also produces a nibble-wide propagate/generate pair. Four such pairs feed an identical unit one level up, which delivers the carries into the nibbles of a 16-bit span. Wider operands stack further levels of the same unit.

The outputs are the sum, the carry-out and the propagate/generate pair of the whole width. A parent lookahead unit can therefore treat the adder as one lane of a wider adder. A parameter selects whether the per-bit propagate used for carries is formed with OR or with XOR. The choice does not change the carries. It changes only the meaning of the exported propagate.

Top module: `lookahead_adder`

## Requirements
- R1: `sum` equals (`opA` + `opB` + `carryIn`) modulo 2^WIDTH for every input combination, including all-zero inputs.
- R2: `carryOut` equals bit WIDTH of `opA` + `opB` + `carryIn`.
- R3: `groupGen` is 1 exactly when `opA` + `opB`, with no carry-in, overflows WIDTH bits.
- R4: `carryOut` equals `groupGen` OR (`groupProp` AND `carryIn`), in both propagate modes.
- R5: With `PROP_OR` = 0, `groupProp` is 1 exactly when every bit of `opA` XOR `opB` is 1.
- R6: With `PROP_OR` = 1, `groupProp` is 1 exactly when every bit of `opA` OR `opB` is 1, and `sum` and `carryOut` are identical to those of the `PROP_OR` = 0 variant for the same inputs.
- R7: WIDTH must be a power of four and at least 16. WIDTH = 16 uses two lookahead levels and WIDTH = 64 uses three, and both give correct sums and carry-outs.
- R8: A carry-in applied to an operand pair that propagates across every bit reaches `carryOut`: all-ones plus zero with carry-in 1 gives sum 0 and carry-out 1. A carry generated just below any nibble or 16-bit boundary lands in the bit above that boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum, modulo 2^WIDTH |
| carryOut | output | 1 | Carry out of the top bit |
| groupProp | output | 1 | Whole-width propagate for cascading |
| groupGen | output | 1 | Whole-width generate for cascading |

## Verification
The hardest paths to reach from the ports are those where the carry into a nibble comes from an upper-level unit, two or three levels removed from the bit that generated it. Random operands seldom build long propagate runs that end exactly at a nibble or 16-bit boundary. The stimulus therefore includes operands of the form 2^k − 1 plus one for every k that is a multiple of four. It also includes all-ones operands with carry-in, and alternating patterns that set propagate on every bit. The group-level carry-out of every unit is then forced to agree with the carry that the next level delivers, and random vectors fill in the rest.

// File: rtl/lookahead_pkg.sv
package lookahead_pkg;

  // Four propagate/generate pairs entering one lookahead unit, lane 0 least significant.
  typedef struct packed {
    logic [3:0] prop;
    logic [3:0] gen;
  } quadPg_t;

  function automatic bit isPowerOfFour(input int value);
    int probe;
    probe = 1;
    while (probe < value) probe = probe * 4;
    return (probe == value);
  endfunction

  function automatic int levelCount(input int value);
    int probe;
    int levels;
    probe  = 1;
    levels = 0;
    while (probe < value) begin
      probe  = probe * 4;
      levels = levels + 1;
    end
    return levels;
  endfunction

endpackage

// File: rtl/la_lookahead_unit.sv
module la_lookahead_unit
  import lookahead_pkg::*;
(
  input  quadPg_t    quadIn,
  input  logic       carryIn,
  output logic [3:0] laneCarry,
  output logic       groupProp,
  output logic       groupGen,
  output logic       carryOut
);

  logic [3:0] p;
  logic [3:0] g;

  assign p = quadIn.prop;
  assign g = quadIn.gen;

  // Carries into lanes 1..3, each expanded in full from carryIn.
  always_comb begin
    laneCarry[0] = carryIn;
    laneCarry[1] = g[0] | (p[0] & carryIn);
    laneCarry[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & carryIn);
    laneCarry[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                 | (p[2] & p[1] & p[0] & carryIn);
  end

  assign carryOut = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                  | (p[3] & p[2] & p[1] & g[0])
                  | (p[3] & p[2] & p[1] & p[0] & carryIn);

  // Group pair for the next level; independent of carryIn.
  assign groupGen  = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                   | (p[3] & p[2] & p[1] & g[0]);
  assign groupProp = &p;

  always_comb begin
    if (!$isunknown({quadIn, carryIn})) begin
      AST_UNIT_SPLIT: assert (carryOut == (groupGen | (groupProp & carryIn))); // R4
    end
  end

endmodule

// File: rtl/la_sum_path.sv
module la_sum_path #(
  parameter int WIDTH   = 64,
  parameter bit PROP_OR = 1'b0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] bitCarry,
  output logic [WIDTH-1:0] bitProp,
  output logic [WIDTH-1:0] bitGen,
  output logic [WIDTH-1:0] sum
);

  logic [WIDTH-1:0] halfSum;

  assign halfSum = opA ^ opB;
  assign bitGen  = opA & opB;

  if (PROP_OR) begin : g_prop_or
    assign bitProp = opA | opB;
    always_comb begin
      if (!$isunknown({opA, opB})) begin
        AST_OR_PROP_COVERS_GEN: assert ((bitGen & ~bitProp) == '0); // R6
      end
    end
  end else begin : g_prop_xor
    assign bitProp = halfSum;
    always_comb begin
      if (!$isunknown({opA, opB})) begin
        AST_XOR_PROP_EXCLUSIVE: assert ((bitGen & bitProp) == '0); // R5
      end
    end
  end

  // The sum always uses the exclusive form, whatever the carry propagate is.
  assign sum = halfSum ^ bitCarry;

endmodule

// File: rtl/la_carry_tree.sv
module la_carry_tree
  import lookahead_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] bitProp,
  input  logic [WIDTH-1:0] bitGen,
  input  logic             carryIn,
  output logic [WIDTH-1:0] bitCarry,
  output logic             topProp,
  output logic             topGen,
  output logic             carryOut
);

  localparam int UNITS = WIDTH / 4;

  if (WIDTH == 4) begin : g_leaf
    la_lookahead_unit i_unit (
      .quadIn   ('{prop: bitProp, gen: bitGen}),
      .carryIn  (carryIn),
      .laneCarry(bitCarry),
      .groupProp(topProp),
      .groupGen (topGen),
      .carryOut (carryOut)
    );
  end else begin : g_node
    logic [UNITS-1:0] upProp;
    logic [UNITS-1:0] upGen;
    logic [UNITS-1:0] upCarry;
    logic [UNITS-1:0] unitCout;

    for (genvar k = 0; k < UNITS; k++) begin : g_unit
      quadPg_t quad;
      assign quad.prop = bitProp[4*k +: 4];
      assign quad.gen  = bitGen[4*k +: 4];

      la_lookahead_unit i_unit (
        .quadIn   (quad),
        .carryIn  (upCarry[k]),
        .laneCarry(bitCarry[4*k +: 4]),
        .groupProp(upProp[k]),
        .groupGen (upGen[k]),
        .carryOut (unitCout[k])
      );

      // The carry a unit would pass upward must match what the upper level hands to its neighbour.
      if (k < UNITS - 1) begin : g_mid
        always_comb begin
          if (!$isunknown({bitProp, bitGen, carryIn})) begin
            AST_LEVEL_HANDOFF: assert (unitCout[k] == upCarry[k+1]); // R8
          end
        end
      end else begin : g_last
        always_comb begin
          if (!$isunknown({bitProp, bitGen, carryIn})) begin
            AST_LEVEL_TOP_CARRY: assert (unitCout[k] == carryOut); // R2
          end
        end
      end
    end

    // Next level: the same lookahead unit, applied to the group pairs.
    la_carry_tree #(.WIDTH(UNITS)) i_upper (
      .bitProp (upProp),
      .bitGen  (upGen),
      .carryIn (carryIn),
      .bitCarry(upCarry),
      .topProp (topProp),
      .topGen  (topGen),
      .carryOut(carryOut)
    );
  end

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
  import lookahead_pkg::*;
#(
  parameter int WIDTH   = 64,
  parameter bit PROP_OR = 1'b0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             groupProp,
  output logic             groupGen
);

  localparam int LEVELS = levelCount(WIDTH);

  if (!isPowerOfFour(WIDTH) || LEVELS < 2) begin : g_bad_width
    $error("lookahead_adder: WIDTH must be a power of four and at least 16");
  end

  logic [WIDTH-1:0] bitProp;
  logic [WIDTH-1:0] bitGen;
  logic [WIDTH-1:0] bitCarry;

  la_sum_path #(.WIDTH(WIDTH), .PROP_OR(PROP_OR)) i_datapath (
    .opA     (opA),
    .opB     (opB),
    .bitCarry(bitCarry),
    .bitProp (bitProp),
    .bitGen  (bitGen),
    .sum     (sum)
  );

  la_carry_tree #(.WIDTH(WIDTH)) i_control (
    .bitProp (bitProp),
    .bitGen  (bitGen),
    .carryIn (carryIn),
    .bitCarry(bitCarry),
    .topProp (groupProp),
    .topGen  (groupGen),
    .carryOut(carryOut)
  );

  logic [WIDTH:0] refTotal;
  logic [WIDTH:0] refNoCin;
  assign refTotal = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
  assign refNoCin = {1'b0, opA} + {1'b0, opB};

  always_comb begin
    if (!$isunknown({opA, opB, carryIn})) begin
      AST_SUM_EXACT:   assert (sum == refTotal[WIDTH-1:0]);                   // R1
      AST_CARRY_EXACT: assert (carryOut == refTotal[WIDTH]);                  // R2
      AST_GEN_NO_CIN:  assert (groupGen == refNoCin[WIDTH]);                  // R3
      AST_TOP_SPLIT:   assert (carryOut == (groupGen | (groupProp & carryIn))); // R4
    end
  end

endmodule

// File: tb/test_lookahead_adder.sv
module test_lookahead_adder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 4 ns period

  logic [63:0] opA;
  logic [63:0] opB;
  logic        carryIn;

  logic [63:0] sumX, sumO;
  logic [15:0] sum16;
  logic        coutX, coutO, cout16;
  logic        gpX, ggX, gpO, ggO, gp16, gg16;

  lookahead_adder #(.WIDTH(64), .PROP_OR(1'b0)) i_lookahead_adder (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sum(sumX), .carryOut(coutX), .groupProp(gpX), .groupGen(ggX));

  lookahead_adder #(.WIDTH(64), .PROP_OR(1'b1)) i_lookahead_adder_or (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sum(sumO), .carryOut(coutO), .groupProp(gpO), .groupGen(ggO));

  lookahead_adder #(.WIDTH(16), .PROP_OR(1'b0)) i_lookahead_adder_16 (
    .opA(opA[15:0]), .opB(opB[15:0]), .carryIn(carryIn),
    .sum(sum16), .carryOut(cout16), .groupProp(gp16), .groupGen(gg16));

  int  nChecks = 0;
  int  nFail   = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one vector and checks every output of all three instances against arithmetic.
  task automatic applyVec(input logic [63:0] a, input logic [63:0] b, input logic ci);
    logic [64:0] tot;
    logic [64:0] noCin;
    logic [16:0] tot16;
    logic [16:0] noCin16;
    @(posedge clk);
    opA <= a; opB <= b; carryIn <= ci;
    @(negedge clk);
    tot     = {1'b0, a} + {1'b0, b} + {64'd0, ci};
    noCin   = {1'b0, a} + {1'b0, b};
    tot16   = {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'd0, ci};
    noCin16 = {1'b0, a[15:0]} + {1'b0, b[15:0]};
    chk(sumX == tot[63:0], "R1 sum", sumX, tot[63:0]);
    chk(coutX == tot[64], "R2 carryOut", coutX, tot[64]);
    chk(ggX == noCin[64], "R3 groupGen", ggX, noCin[64]);
    chk(coutX == (ggX | (gpX & ci)), "R4 split xor", coutX, ggX | (gpX & ci));
    chk(coutO == (ggO | (gpO & ci)), "R4 split or", coutO, ggO | (gpO & ci));
    chk(gpX == &(a ^ b), "R5 groupProp xor", gpX, &(a ^ b));
    chk(gpO == &(a | b), "R6 groupProp or", gpO, &(a | b));
    chk({coutO, sumO} == tot, "R6 or-mode result", {coutO, sumO}, tot);
    chk({cout16, sum16} == tot16, "R7 16-bit result", {cout16, sum16}, tot16);
    chk(gg16 == noCin16[16], "R7 16-bit groupGen", gg16, noCin16[16]);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(sumX == 64'd0 && coutX == 1'b0, "R1 reset idle sum", {coutX, sumX}, 65'd0);
    chk(ggX == 1'b0 && gpX == 1'b0, "R3 reset idle group", {ggX, gpX}, 2'b00);
  endtask

  task automatic testAllOnesPlusOne();
    applyVec('1, 64'd1, 1'b0);
    chk(sumX == 64'd0 && coutX, "R8 all ones plus one", {coutX, sumX}, {1'b1, 64'd0});
    applyVec('1, 64'd0, 1'b1);
    chk(sumX == 64'd0 && coutX && gpX && !ggX, "R8 full-width carry-in",
        {gpX, ggX, coutX, sumX}, {1'b1, 1'b0, 1'b1, 64'd0});
    applyVec('1, 64'd0, 1'b0);
    chk(sumX == '1 && !coutX, "R8 propagate without carry-in", {coutX, sumX}, {1'b0, {64{1'b1}}});
  endtask

  task automatic testAlternating();
    applyVec({32{2'b01}}, {32{2'b10}}, 1'b1);
    applyVec({32{2'b10}}, {32{2'b10}}, 1'b0);
    applyVec({32{2'b01}}, {32{2'b01}}, 1'b1);
    applyVec({16{4'hA}}, {16{4'h5}}, 1'b0);
  endtask

  task automatic testBoundaries();
    for (int k = 4; k < 64; k += 4) begin
      logic [63:0] low;
      logic [63:0] want;
      low  = (64'd1 << k) - 64'd1;
      want = 64'd1 << k;
      applyVec(low, 64'd1, 1'b0);
      chk(sumX == want, "R8 boundary landing", sumX, want);
      applyVec(low, 64'd0, 1'b1);
    end
  endtask

  task automatic testRandom();
    for (int n = 0; n < 300; n++) begin
      applyVec({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
    end
  endtask

  initial begin
    opA = '0; opB = '0; carryIn = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    testReset();
    testAllOnesPlusOne();
    testAlternating();
    testBoundaries();
    testRandom();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule